// File: doc/BRIEF.md
# Keycode Event Queue with Interrupt

This block collects key presses from a scanned key matrix and holds them for a CPU. The key scanner gives it a one-cycle press strobe, together with the row being driven and the column that answered. On each strobe the block packs that position and the current levels of the shift and control keys into one 8-bit keycode. It then appends the keycode to a small first-in first-out queue. An interrupt request output stays high for as long as the queue holds at least one keycode.

The CPU reads through a register port with one select line. With the select line low, a read strobe pops the oldest keycode onto the 8-bit read bus. With the select line high, the read returns a status byte, which gives the queue occupancy and a sticky overrun flag. The overrun flag records that a press arrived while the queue was full and was lost. A status read clears it. Read data is registered, so it appears on the bus in the cycle after the read strobe.

Top module: `key_event_fifo`

## Requirements
- R1: After reset the interrupt output is 0, the read bus is 0x00, the queue is empty and the overrun flag is clear.
- R2: A stored keycode has control in bit 7, shift in bit 6, the scan row in bits 5:3 and the return column in bits 2:0, all sampled in the cycle of the press strobe.
- R3: The queue holds up to 8 keycodes, and data reads return them in the order of arrival.
- R4: In the cycle after a press strobe, the interrupt output is 1.
- R5: The interrupt output is 0 in the cycle after the data read that removes the last keycode, and it stays 0 while the queue is empty.
- R6: A press strobe that arrives while the queue is full and no data read happens in the same cycle is discarded, and the stored keycodes are unchanged.
- R7: A discarded press sets the overrun flag. The flag stays set until a status read, and that status read returns it as set.
- R8: A status read (select = 1) returns bit 7 = overrun, bits 3:0 = the number of stored keycodes and bits 6:4 = 0. It does not remove any keycode.
- R9: A data read (select = 0) of an empty queue returns 0x00 and leaves the queue empty.
- R10: A press strobe and a data read in the same cycle on a full queue both take effect. The oldest keycode is returned, the new one is stored, and the overrun flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_strobe | input | 1 | One-cycle pulse for a detected key press |
| key_row | input | 3 | Scan row of the pressed key |
| key_col | input | 3 | Return column of the pressed key |
| shift_lvl | input | 1 | Current level of the shift key |
| ctrl_lvl | input | 1 | Current level of the control key |
| cpu_rd | input | 1 | CPU read strobe, one cycle per read |
| cpu_sel | input | 1 | Register select: 0 = keycode data, 1 = status |
| cpu_dout | output | 8 | Registered read data, valid in the cycle after cpu_rd |
| irq | output | 1 | High while the queue holds any keycode |

## Verification
The bench fills the queue exactly to its depth and sends one more press. A design that overwrote the oldest entry or moved a pointer on the dropped press would then return keycodes out of order or skip one. It checks that the overrun flag survives later activity and is cleared only by a status read, which catches a flag that clears itself or that a data read clears. A press combined with a read on a full queue must neither flag an overrun nor lose the new keycode. The bench also pops the last entry and reads an empty queue to catch an interrupt that falls one cycle late, or a pointer that moves on an empty read.

// File: rtl/kef_pkg.sv
package kef_pkg;
    // Number of bits taken by the two modifier levels at the top of a keycode.
    localparam int MOD_BITS = 2;

    // Packs a key position and modifier levels into one keycode (R2 layout).
    function automatic logic [7:0] pack_code8(input logic ctrl, input logic shift,
                                              input logic [2:0] row, input logic [2:0] col);
        return {ctrl, shift, row, col};
    endfunction
endpackage

// File: rtl/kef_keycode_former.sv
// Keycode former.
// Packs control, shift, row and column into one keycode with the modifiers on top.
// Assumes: the inputs are steady in the cycle of the press strobe. Purely combinational.
module kef_keycode_former #(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 3,
    localparam int CODE_W = kef_pkg::MOD_BITS + ROW_W + COL_W
) (
    input  logic              ctrl_i,
    input  logic              shift_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [COL_W-1:0]  col_i,
    output logic [CODE_W-1:0] code_o
);
    // Field concatenation, MSB to LSB: control, shift, row, column.
    always_comb begin
        code_o = {ctrl_i, shift_i, row_i, col_i};
    end
endmodule

// File: rtl/kef_ring_store.sv
// Ring-buffer storage for keycodes.
// One register per entry, written through a one-hot select made by a generate loop.
// Assumes: the caller never asserts push_i when the store is full unless pop_i is also set.
// The head entry is presented combinationally on head_o.
module kef_ring_store #(
    parameter int DEPTH  = 8,
    parameter int WIDTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o,
    output logic             empty_o
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] entry_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;

    // Wraps a pointer at the configured depth, which need not be a power of two.
    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    // Per-entry write: only the entry addressed by the write pointer takes new data.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q[gi] <= '0;
            else if (push_i && (wr_ptr_q == PTR_W'(gi)))
                entry_q[gi] <= data_i;
        end
    end

    // Write pointer advances on every accepted push.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_ptr_q <= '0;
        else if (push_i)
            wr_ptr_q <= next_ptr(wr_ptr_q);
    end

    // Read pointer advances on every pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_ptr_q <= '0;
        else if (pop_i)
            rd_ptr_q <= next_ptr(rd_ptr_q);
    end

    // Occupancy follows pushes and pops; a simultaneous pair leaves it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (push_i && !pop_i)
            count_q <= count_q + 1'b1;
        else if (pop_i && !push_i)
            count_q <= count_q - 1'b1;
    end

    // Flags and head output.
    always_comb begin
        head_o  = entry_q[rd_ptr_q];
        count_o = count_q;
        full_o  = (count_q == FULL_CNT);
        empty_o = (count_q == '0);
    end
endmodule

// File: rtl/kef_overrun_flag.sv
// Sticky overrun flag.
// It is set by a discarded press and cleared by a status read. When both happen in
// one cycle, the set wins so that the new loss is not hidden.
module kef_overrun_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // Set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/kef_cpu_port.sv
// CPU read port.
// Registers either the head keycode or the status byte onto the read bus.
// Assumes: the caller has already worked out whether a data read pops an entry.
// A data read of an empty queue puts zero on the bus.
module kef_cpu_port #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_data_i,
    input  logic              rd_stat_i,
    input  logic              empty_i,
    input  logic [DATA_W-1:0] head_i,
    input  logic              ovr_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [DATA_W-1:0] dout_o
);
    logic [DATA_W-1:0] stat_byte;
    logic [DATA_W-1:0] dout_q;

    // Status layout: overrun at the top bit, occupancy in the low bits, zeros between.
    always_comb begin
        stat_byte = '0;
        stat_byte[DATA_W-1] = ovr_i;
        stat_byte[CNT_W-1:0] = count_i;
    end

    // Read bus register; it holds its value between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout_q <= '0;
        else if (rd_stat_i)
            dout_q <= stat_byte;
        else if (rd_data_i)
            dout_q <= empty_i ? '0 : head_i;
    end

    assign dout_o = dout_q;
endmodule

// File: rtl/key_event_fifo.sv
// Keycode event queue with interrupt (top).
// Packs key presses into keycodes and queues them. It raises irq while the queue is
// non-empty and serves CPU reads of data or status.
// Assumes: key_strobe and cpu_rd are one-cycle pulses synchronous to clk.
module key_event_fifo #(
    parameter int DEPTH  = 8,
    parameter int ROW_W  = 3,
    parameter int COL_W  = 3,
    localparam int CODE_W = kef_pkg::MOD_BITS + ROW_W + COL_W,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_strobe,
    input  logic [ROW_W-1:0]  key_row,
    input  logic [COL_W-1:0]  key_col,
    input  logic              shift_lvl,
    input  logic              ctrl_lvl,
    input  logic              cpu_rd,
    input  logic              cpu_sel,
    output logic [CODE_W-1:0] cpu_dout,
    output logic              irq
);
    logic [CODE_W-1:0] new_code;
    logic [CODE_W-1:0] head_code;
    logic [CNT_W-1:0]  occ;
    logic              is_full, is_empty;
    logic              rd_data, rd_stat, do_pop, do_push, drop_evt;
    logic              ovr_flag;

    // Decode the CPU access and the queue moves it causes in this cycle.
    always_comb begin
        rd_data  = cpu_rd && !cpu_sel;
        rd_stat  = cpu_rd && cpu_sel;
        do_pop   = rd_data && !is_empty;
        do_push  = key_strobe && (!is_full || do_pop);
        drop_evt = key_strobe && is_full && !do_pop;
    end

    kef_keycode_former #(.ROW_W(ROW_W), .COL_W(COL_W)) u_former (
        .ctrl_i  (ctrl_lvl),
        .shift_i (shift_lvl),
        .row_i   (key_row),
        .col_i   (key_col),
        .code_o  (new_code)
    );

    kef_ring_store #(.DEPTH(DEPTH), .WIDTH(CODE_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (do_push),
        .data_i  (new_code),
        .pop_i   (do_pop),
        .head_o  (head_code),
        .count_o (occ),
        .full_o  (is_full),
        .empty_o (is_empty)
    );

    kef_overrun_flag u_ovr (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (drop_evt),
        .clr_i  (rd_stat),
        .flag_o (ovr_flag)
    );

    kef_cpu_port #(.DATA_W(CODE_W), .CNT_W(CNT_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_data_i (rd_data),
        .rd_stat_i (rd_stat),
        .empty_i   (is_empty),
        .head_i    (head_code),
        .ovr_i     (ovr_flag),
        .count_i   (occ),
        .dout_o    (cpu_dout)
    );

    // The interrupt request follows the registered occupancy.
    always_comb begin
        irq = !is_empty;
    end
endmodule

// File: rtl/key_event_fifo_chk.sv
// Property checker for key_event_fifo. It is attached to the top module by the bind below.
module key_event_fifo_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4,
    parameter int DW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          key_strobe,
    input logic          cpu_rd,
    input logic          cpu_sel,
    input logic [DW-1:0] cpu_dout,
    input logic          irq,
    input logic [CNT_W-1:0] occ,
    input logic          ovr_flag
);
    AST_IRQ_AFTER_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
        key_strobe |=> irq); // R4
    AST_IRQ_FALLS_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_sel && occ == CNT_W'(1) && !key_strobe) |=> !irq); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH)); // R3
    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_strobe && occ == CNT_W'(DEPTH) && !(cpu_rd && !cpu_sel)) |=> ovr_flag); // R7
    AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (key_strobe && occ == CNT_W'(DEPTH) && !cpu_rd) |=> occ == CNT_W'(DEPTH)); // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !(cpu_rd && cpu_sel)) |=> ovr_flag); // R7
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_sel && occ == '0) |=> (cpu_dout == '0)); // R9
    AST_STATUS_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_sel && !key_strobe) |=> $stable(occ)); // R8
endmodule

bind key_event_fifo key_event_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DW(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_strobe (key_strobe),
    .cpu_rd     (cpu_rd),
    .cpu_sel    (cpu_sel),
    .cpu_dout   (cpu_dout),
    .irq        (irq),
    .occ        (occ),
    .ovr_flag   (ovr_flag)
);

// File: tb/key_event_fifo_tb_top.sv
module key_event_fifo_tb_top;
    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_strobe = 1'b0;
    logic [2:0] key_row = '0;
    logic [2:0] key_col = '0;
    logic       shift_lvl = 1'b0;
    logic       ctrl_lvl = 1'b0;
    logic       cpu_rd = 1'b0;
    logic       cpu_sel = 1'b0;
    logic [7:0] cpu_dout;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model and scoreboard.
    logic [7:0] mq[$];
    bit         m_ovr = 0;
    logic [7:0] sb_exp[$];
    string      sb_tag[$];
    logic       was_rd = 1'b0;

    always #5 clk = ~clk;

    key_event_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .key_strobe(key_strobe), .key_row(key_row),
        .key_col(key_col), .shift_lvl(shift_lvl), .ctrl_lvl(ctrl_lvl),
        .cpu_rd(cpu_rd), .cpu_sel(cpu_sel), .cpu_dout(cpu_dout), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Monitor: for each read issued in the previous cycle, pop and compare.
    always @(posedge clk) was_rd <= cpu_rd;
    always @(negedge clk) begin
        if (was_rd && rst_n && sb_exp.size() > 0)
            check(sb_tag.pop_front(), cpu_dout, sb_exp.pop_front());
    end

    // Model side of a press; pop_first is set when a data read shares the cycle.
    function automatic void model_press(input logic [7:0] code, input bit pop_first);
        if (pop_first && mq.size() > 0) begin
            sb_exp.push_back(mq.pop_front());
            sb_tag.push_back("R10");
        end
        if (mq.size() < DEPTH) mq.push_back(code);
        else m_ovr = 1;
    endfunction

    task automatic press(input bit c, input bit s, input int r, input int k, input bit with_rd);
        @(posedge clk); #2;
        key_strobe = 1; ctrl_lvl = c; shift_lvl = s; key_row = 3'(r); key_col = 3'(k);
        cpu_rd = with_rd; cpu_sel = 0;
        model_press({c, s, 3'(r), 3'(k)}, with_rd);
        @(posedge clk); #2;
        key_strobe = 0; cpu_rd = 0;
    endtask

    task automatic read_data(input string tag);
        @(posedge clk); #2;
        cpu_rd = 1; cpu_sel = 0;
        sb_exp.push_back(mq.size() > 0 ? mq.pop_front() : 8'h00);
        sb_tag.push_back(tag);
        @(posedge clk); #2;
        cpu_rd = 0;
    endtask

    task automatic read_stat(input string tag);
        @(posedge clk); #2;
        cpu_rd = 1; cpu_sel = 1;
        sb_exp.push_back({m_ovr, 3'b000, 4'(mq.size())});
        sb_tag.push_back(tag);
        m_ovr = 0;
        @(posedge clk); #2;
        cpu_rd = 0; cpu_sel = 0;
    endtask

    task automatic check_irq(input string tag);
        @(negedge clk);
        check(tag, {7'b0, irq}, {7'b0, mq.size() != 0});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 dout", cpu_dout, 8'h00);
        @(posedge clk); #2;
        rst_n = 1;
        read_stat("R1 status");
        // Single keycode: ctrl=1 shift=0 row=5 col=2 -> 0xAA (R2).
        press(1, 0, 5, 2, 0);
        check_irq("R4");
        read_data("R2 layout");
        check_irq("R5");
        read_data("R9 empty read");
        read_stat("R9 count stays 0");
        press(0, 1, 3, 7, 0);
        read_data("R2 shift");
        // Fill to the depth with varied patterns (R3).
        for (int i = 0; i < DEPTH; i++) press(i[0], i[1], i, 7 - i, 0);
        check_irq("R4 full");
        read_stat("R8 full count");
        press(1, 1, 7, 7, 0);          // dropped (R6)
        read_stat("R7 overrun set");
        read_stat("R7 overrun cleared");
        press(1, 1, 6, 6, 1);          // press with data read on a full queue (R10)
        read_stat("R10 no overrun");
        for (int i = 0; i < DEPTH; i++) read_data("R3 order");
        check_irq("R5 drained");
        // Wrap-around with interleaving.
        for (int i = 0; i < 5; i++) begin
            press(i[1], i[0], i + 2, i, 0);
            press(i[0], 1, i, i + 3, 0);
            read_data("R3 wrap");
        end
        read_stat("R8 partial count");
        for (int i = 0; i < 5; i++) read_data("R3 wrap drain");
        check_irq("R5 final");
        repeat (3) @(posedge clk);
        if (sb_exp.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb_exp.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #2000000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule